// File: doc/BRIEF.md
# SGPIO Drive Status Serializer

This block is the initiator end of a serial general-purpose I/O link that tells a storage backplane the state of six drive ports. It divides the system clock down to a slow serial clock and marks each frame with a one-period pulse on the load line. The next four periods of the load line carry a vendor field. Across the whole frame, two open-drain data lanes carry three status bits for each drive. The drives always go out in the order 0 to 5, and a new frame follows at once.

The status and vendor inputs are copied into a shadow store at the first serial clock rise of every frame, so software can update them at any time without tearing a frame. When the enable input is removed, the serial clock parks high, the load line drops to 0 and both data lanes are released. When enable returns, a fresh frame starts with drive 0.

Top module: `sgpio_status_tx`

## Requirements
- R1: While enabled, the serial clock period is 2*half_div system clock cycles. A half_div of 0 acts as 1.
- R2: Load and data outputs change only in the system cycle in which the serial clock goes from 0 to 1. They hold their values across every serial clock fall.
- R3: A frame lasts 18 serial clock periods. In period 0 of every frame the load line is 1.
- R4: In periods 1 to 4 the load line carries vendor_pat most significant bit first. In all later periods of the frame it is 0.
- R5: In frame period p, both data lanes carry drive p/3, slot bit p%3, with slot bits sent in the order activity, locate, fault. For status inputs, bit 3*d+2 is the activity bit of drive d, bit 3*d+1 its locate bit and bit 3*d its fault bit. Drives go out in the order 0 to 5, and frames follow back to back.
- R6: Lane 0 carries status_a and lane 1 carries status_b.
- R7: Status and vendor inputs are sampled at period 0 of each frame. A change during a frame first appears in the next frame.
- R8: Each data lane is open-drain. An enable of 1 pulls the line low to send a 0. An enable of 0 releases the line, which sends a 1.
- R9: After reset and while enable is 0, the serial clock is 1, the load line is 0 and both lanes are released. The first rise after enabling starts a frame at period 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Runs the link when 1 |
| half_div | input | 16 | System cycles per half serial clock period |
| status_a | input | 18 | Primary per-drive status, 3 bits per drive |
| status_b | input | 18 | Secondary per-drive status, 3 bits per drive |
| vendor_pat | input | 4 | Vendor field sent after the load pulse |
| sclk | output | 1 | Serial clock |
| sload | output | 1 | Frame marker and vendor field |
| sdata0_oe | output | 1 | Lane 0 pull-low enable |
| sdata1_oe | output | 1 | Lane 1 pull-low enable |

## Verification
The scoreboard checks every serial clock rise against an expected slot value computed from the inputs, and it measures the spacing between rises for several divider settings, including a setting of 0. If the slot order inside a drive were reversed, or the vendor field went out least significant bit first, the popped slots would not match. Inputs are changed in the middle of a frame, and a design without the shadow store would show the new bits early. The enable is dropped and restored in the middle of a frame. A design that resumed where it stopped, instead of starting again at the load pulse, would fail at the first slot. Data sampled at each serial clock fall is compared with the value set at the rise before it, so any output that moves between edges is caught.

// File: rtl/sgpio_pkg.sv
// Shared constants and slot-indexing helper for the drive status serializer.
package sgpio_pkg;
    localparam int BITS_PER_DRIVE = 3;   // activity, locate, fault
    localparam int SLOT_ACT       = 2;   // bit position of activity within a drive slot
    localparam int SLOT_LOC       = 1;
    localparam int SLOT_FLT       = 0;

    // Maps a frame period to the status vector bit sent in that period.
    function automatic int period_to_bit(input int period);
        return (period / BITS_PER_DRIVE) * BITS_PER_DRIVE
             + (BITS_PER_DRIVE - 1 - (period % BITS_PER_DRIVE));
    endfunction
endpackage

// File: rtl/sgpio_clkgen.sv
// Serial clock generator: divides clk by 2*half_div (0 treated as 1).
// Parks sclk high while disabled and produces one-cycle rise/fall ticks that
// coincide with the cycle in which the registered sclk changes.
module sgpio_clkgen #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic [DIV_W-1:0] half_div,
    output logic             sclk,
    output logic             rise_tick,
    output logic             fall_tick
);
    logic [DIV_W-1:0] cnt_q;
    logic [DIV_W-1:0] half_eff;
    logic             sclk_q;
    logic             half_done;

    // Effective half period and terminal count detection.
    always_comb begin
        half_eff  = (half_div == '0) ? DIV_W'(1) : half_div;
        half_done = (cnt_q >= half_eff - DIV_W'(1));
        rise_tick = enable && half_done && !sclk_q;
        fall_tick = enable && half_done && sclk_q;
    end

    // Half-period counter and serial clock toggle.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            cnt_q  <= '0;
            sclk_q <= 1'b1;
        end else if (half_done) begin
            cnt_q  <= '0;
            sclk_q <= ~sclk_q;
        end else begin
            cnt_q  <= cnt_q + DIV_W'(1);
        end
    end

    assign sclk = sclk_q;

    assert_idle_high_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> sclk_q);

    assert_rise_edge_R1: assert property (@(posedge clk) disable iff (!rst_n)
        rise_tick |=> (sclk_q && cnt_q == '0));

    assert_hold_level_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && !rise_tick && !fall_tick) |=> $stable(sclk_q));
endmodule

// File: rtl/sgpio_frame_seq.sv
// Frame sequencer: tracks the period within a frame, shadows the status and
// vendor inputs at each frame start, and drives the load line.
// Assumes FRAME_LEN >= VENDOR_W + 1 so the vendor field fits in one frame.
module sgpio_frame_seq #(
    parameter int NUM_DRIVES = 6,
    parameter int VENDOR_W   = 4,
    parameter int STAT_W     = NUM_DRIVES * sgpio_pkg::BITS_PER_DRIVE,
    parameter int PIDX_W     = $clog2(STAT_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              rise_tick,
    input  logic [STAT_W-1:0] status_a,
    input  logic [STAT_W-1:0] status_b,
    input  logic [VENDOR_W-1:0] vendor_pat,
    output logic              running,
    output logic [PIDX_W-1:0] pidx,
    output logic [STAT_W-1:0] shadow_a,
    output logic [STAT_W-1:0] shadow_b,
    output logic              load
);
    localparam int FRAME_LEN = STAT_W;
    localparam int VIDX_W    = (VENDOR_W > 1) ? $clog2(VENDOR_W) : 1;
    localparam logic [PIDX_W-1:0] LAST_P = PIDX_W'(FRAME_LEN - 1);

    logic                run_q;
    logic [PIDX_W-1:0]   pidx_q;
    logic [VENDOR_W-1:0] vend_q;
    logic                frame_start;

    // A frame begins on the first rise after enabling or after the last period.
    assign frame_start = rise_tick && (!run_q || pidx_q == LAST_P);

    // Period counter and running flag.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            run_q  <= 1'b0;
            pidx_q <= '0;
        end else if (frame_start) begin
            run_q  <= 1'b1;
            pidx_q <= '0;
        end else if (rise_tick) begin
            pidx_q <= pidx_q + PIDX_W'(1);
        end
    end

    // Shadow capture of all inputs at the start of each frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shadow_a <= '0;
            shadow_b <= '0;
            vend_q   <= '0;
        end else if (enable && frame_start) begin
            shadow_a <= status_a;
            shadow_b <= status_b;
            vend_q   <= vendor_pat;
        end
    end

    // Load line: pulse in period 0, vendor field MSB first, then low.
    always_comb begin
        int p;
        p = int'(pidx_q);
        load = 1'b0;
        if (run_q) begin
            if (p == 0)
                load = 1'b1;
            else if (p <= VENDOR_W)
                load = vend_q[VIDX_W'(VENDOR_W - p)];
        end
    end

    assign running = run_q;
    assign pidx    = pidx_q;

    assert_pidx_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        pidx_q <= LAST_P);

    assert_load_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && frame_start) |=> (load && pidx_q == '0));

    assert_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && rise_tick && run_q && pidx_q == LAST_P) |=> (pidx_q == '0));

    assert_shadow_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_start |=> ($stable(shadow_a) && $stable(shadow_b)));
endmodule

// File: rtl/sgpio_od_lane.sv
// One open-drain data lane: selects the shadowed status bit for the current
// frame period and converts it to a pull-low enable (1 = drive 0).
// Assumes pidx stays below the status width.
module sgpio_od_lane #(
    parameter int STAT_W = 18,
    parameter int PIDX_W = $clog2(STAT_W)
) (
    input  logic              running,
    input  logic [PIDX_W-1:0] pidx,
    input  logic [STAT_W-1:0] shadow,
    output logic              pull_low
);
    localparam int IDX_W = $clog2(STAT_W);

    // Slot bit select and open-drain encoding.
    always_comb begin
        int bi;
        bi = sgpio_pkg::period_to_bit(int'(pidx));
        pull_low = running && !shadow[IDX_W'(bi)];
    end
endmodule

// File: rtl/sgpio_status_tx.sv
// Top of the drive status serializer: serial clock generator, frame
// sequencer and two open-drain data lanes. Outputs change only together with
// a serial clock rise. Assumes half_div is changed only while disabled.
module sgpio_status_tx #(
    parameter int NUM_DRIVES = 6,
    parameter int VENDOR_W   = 4,
    parameter int DIV_W      = 16,
    parameter int NUM_LANES  = 2,
    parameter int STAT_W     = NUM_DRIVES * sgpio_pkg::BITS_PER_DRIVE
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                enable,
    input  logic [DIV_W-1:0]    half_div,
    input  logic [STAT_W-1:0]   status_a,
    input  logic [STAT_W-1:0]   status_b,
    input  logic [VENDOR_W-1:0] vendor_pat,
    output logic                sclk,
    output logic                sload,
    output logic                sdata0_oe,
    output logic                sdata1_oe
);
    localparam int PIDX_W = $clog2(STAT_W);

    logic                          rise_tick;
    logic                          fall_tick;
    logic                          running;
    logic [PIDX_W-1:0]             pidx;
    logic [NUM_LANES-1:0][STAT_W-1:0] shadows;
    logic [NUM_LANES-1:0]          pull_low;

    sgpio_clkgen #(.DIV_W(DIV_W)) u_clk (
        .clk(clk), .rst_n(rst_n), .enable(enable), .half_div(half_div),
        .sclk(sclk), .rise_tick(rise_tick), .fall_tick(fall_tick)
    );

    sgpio_frame_seq #(.NUM_DRIVES(NUM_DRIVES), .VENDOR_W(VENDOR_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .enable(enable), .rise_tick(rise_tick),
        .status_a(status_a), .status_b(status_b), .vendor_pat(vendor_pat),
        .running(running), .pidx(pidx),
        .shadow_a(shadows[0]), .shadow_b(shadows[1]), .load(sload)
    );

    // One lane per data line.
    for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
        sgpio_od_lane #(.STAT_W(STAT_W)) u_lane (
            .running(running), .pidx(pidx),
            .shadow(shadows[l]), .pull_low(pull_low[l])
        );
    end

    assign sdata0_oe = pull_low[0];
    assign sdata1_oe = pull_low[1];

    assert_idle_outputs_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!sload && !sdata0_oe && !sdata1_oe && sclk));

    assert_change_on_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && !rise_tick) |=> ($stable(sload) && $stable(pull_low)));

    assert_fall_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        fall_tick |=> ($stable(sload) && $stable(sdata0_oe) && $stable(sdata1_oe)));
endmodule

// File: tb/sgpio_status_tx_test.sv
// Scoreboard bench: a driver task queues the expected slots of each frame,
// a monitor pops one per serial clock rise and compares.
module sgpio_status_tx_test;
    localparam int CLK_PERIOD = 10;
    localparam int NSTAT      = 18;

    typedef struct packed {
        logic ld;
        logic d0;
        logic d1;
    } slot_t;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             enable = 1'b0;
    logic [15:0]      half_div = 16'd2;
    logic [NSTAT-1:0] status_a = '0;
    logic [NSTAT-1:0] status_b = '0;
    logic [3:0]       vendor_pat = '0;
    logic             sclk, sload, sdata0_oe, sdata1_oe;

    int    checks = 0;
    int    errors = 0;
    slot_t expq[$];
    int    cyc = 0;

    sgpio_status_tx uut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .half_div(half_div),
        .status_a(status_a), .status_b(status_b), .vendor_pat(vendor_pat),
        .sclk(sclk), .sload(sload), .sdata0_oe(sdata0_oe), .sdata1_oe(sdata1_oe)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Driver: queue the 18 expected slots of one frame (R3 R4 R5 R6 R8).
    task automatic push_frame(input logic [NSTAT-1:0] a, input logic [NSTAT-1:0] b,
                              input logic [3:0] v);
        for (int p = 0; p < NSTAT; p++) begin
            slot_t s;
            int    bi;
            bi   = (p / 3) * 3 + (2 - p % 3);
            s.ld = (p == 0) ? 1'b1 : (p <= 4) ? v[4 - p] : 1'b0;
            s.d0 = a[bi];
            s.d1 = b[bi];
            expq.push_back(s);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    // Monitor: compare at every serial clock rise, check spacing and fall stability.
    logic  prev_sclk = 1'b1;
    slot_t last_s;
    bit    have_last = 0;
    int    last_rise = -1;
    always @(negedge clk) begin
        slot_t cur;
        int    h;
        cyc++;
        cur.ld = sload;
        cur.d0 = !sdata0_oe;   // released line reads 1 (R8)
        cur.d1 = !sdata1_oe;
        h = (half_div == 0) ? 1 : int'(half_div);
        if (!enable || !rst_n) begin
            have_last = 0;
            last_rise = -1;
        end else if (sclk && !prev_sclk) begin
            if (last_rise >= 0)
                check(cyc - last_rise == 2 * h, "R1", "serial period",
                      cyc - last_rise, 2 * h);
            last_rise = cyc;
            if (expq.size() == 0) begin
                check(0, "R5", "unexpected slot", int'(cur), -1);
            end else begin
                slot_t e;
                e = expq.pop_front();
                check(cur == e, "R5 R4 R6", "slot ld/d0/d1", int'(cur), int'(e));
            end
            last_s    = cur;
            have_last = 1;
        end else if (!sclk && prev_sclk && have_last) begin
            check(cur == last_s, "R2", "stable at fall", int'(cur), int'(last_s));
        end
        prev_sclk = sclk;
    end

    task automatic check_idle(input string tag);
        check(sclk == 1'b1, "R9", {tag, " sclk"}, int'(sclk), 1);
        check(!sload && !sdata0_oe && !sdata1_oe, "R9", {tag, " load/oe"},
              int'({sload, sdata0_oe, sdata1_oe}), 0);
    endtask

    task automatic run_tests();
        tick(3);
        rst_n = 1'b1;
        tick(1);
        check_idle("reset");

        // Pattern A, two back-to-back frames (R3 R4 R5 R6).
        half_div   = 16'd2;
        status_a   = 18'b101_001_110_011_100_010;
        status_b   = 18'b010_111_000_101_011_100;
        vendor_pat = 4'b1011;
        push_frame(status_a, status_b, vendor_pat);
        push_frame(status_a, status_b, vendor_pat);
        enable = 1'b1;
        wait (expq.size() == 0);
        tick(1);
        enable = 1'b0;
        tick(10);
        check_idle("disabled");

        // Mid-frame input change shows only in the next frame (R7).
        half_div   = 16'd3;
        status_a   = 18'h2A5C3;
        status_b   = 18'h15A3C;
        vendor_pat = 4'b0110;
        push_frame(status_a, status_b, vendor_pat);
        enable = 1'b1;
        wait (expq.size() <= 10);
        tick(1);
        status_a   = 18'h0F0F3;
        status_b   = 18'h3C3C0;
        vendor_pat = 4'b1001;
        push_frame(status_a, status_b, vendor_pat);
        wait (expq.size() == 0);
        tick(1);
        enable = 1'b0;
        tick(8);

        // Disable in mid-frame, then restart from drive 0 (R9).
        half_div = 16'd4;
        status_a = 18'h3FFFF;
        status_b = 18'h00000;
        push_frame(status_a, status_b, vendor_pat);
        enable = 1'b1;
        wait (expq.size() <= 11);
        tick(1);
        enable = 1'b0;
        expq.delete();
        tick(6);
        check_idle("mid-frame stop");
        status_a   = 18'h12345;
        status_b   = 18'h2BCDE;
        vendor_pat = 4'b1110;
        push_frame(status_a, status_b, vendor_pat);
        enable = 1'b1;
        wait (expq.size() == 0);
        tick(1);
        enable = 1'b0;
        tick(6);

        // Divider of 0 acts as 1 (R1).
        half_div   = 16'd0;
        status_a   = 18'h1B6DB;
        status_b   = 18'h24924;
        vendor_pat = 4'b0001;
        push_frame(status_a, status_b, vendor_pat);
        enable = 1'b1;
        wait (expq.size() == 0);
        tick(1);
        enable = 1'b0;
        tick(4);
        check_idle("end");
    endtask

    initial begin
        fork
            run_tests();
            begin
                tick(150000);
                check(0, "WDOG", "watchdog expired", cyc, 0);
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule